// File: doc/BRIEF.md
# Three-Stage Timebase Watchdog

This block is a watchdog built around a free-running 64-bit timebase counter. The counter advances by one on each clock in which the tick enable is high. Software does not load a count. It chooses a timeout by writing a 6-bit period value, which selects one counter bit to watch. Each rising transition of that bit is one expiry. A larger period value selects a lower-order bit, so the timeout is shorter: the interval between expiries is 2^(64 - period) ticks.

If software does not service the watchdog, expiries escalate through two sticky status flags. The first expiry is silent and only arms the first flag. The second expiry sets the second flag, which raises the interrupt when interrupt enable is set. The third expiry requests a reset, provided the reset-control field is non-zero. To service the watchdog, software writes ones to both flags, which clears them.

The reset-control field is write-once. After it holds a non-zero value, it keeps that value until system reset. Clearing interrupt enable and setting the period value to 0 gives the longest possible timeout, which in practice disables the watchdog.

Top module: `stage_watchdog`

## Requirements
- R1: The timebase output is 0 after reset and increments by one on every clock edge at which `tick_en` is high. It holds its value otherwise.
- R2: Period value p watches timebase bit 63-p. An expiry is a rising (0-to-1) transition of the watched bit. Changes on any other bit have no effect on the flags.
- R3: At register address 0 (control), the period value has its bits 1:0 in bits 31:30 and its bits 5:2 in bits 20:17. Interrupt enable is bit 26 and the 2-bit reset-control field is bits 29:28. All other bits read as 0, and the register reads back what was written.
- R4: An expiry while stage flag A (status bit 31, address 1) is clear sets flag A only. The interrupt and the reset request stay low.
- R5: An expiry while flag A is set and flag B (status bit 30) is clear sets flag B. The flags update on the clock edge that follows the edge that raised the watched bit.
- R6: An expiry while both flags are set drives `wd_rst_req` high for exactly one cycle if the reset-control field is non-zero. If the field is 0, the request stays low.
- R7: Writing 1s to status bits 31 and 30 clears the flags (write-one-to-clear). Clearing flag B drops the interrupt in the next cycle.
- R8: Once the reset-control field is non-zero, writes to it are ignored, while period and interrupt enable stay writable.
- R9: A control write that changes the period value never produces an expiry by itself, even if the newly selected bit is 1 while the old one was 0.
- R10: After reset, both flags, the control register, the interrupt and the reset request are all 0.
- R11: `wd_irq` equals flag B ANDed with interrupt enable. With interrupt enable at 0, flag B can be set while `wd_irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase advance enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register, combinational |
| tb_value | output | 64 | Current timebase count |
| wd_irq | output | 1 | Watchdog interrupt level |
| wd_rst_req | output | 1 | One-cycle reset request |

## Verification
Timing, counted from the clock edge E that moves the counter onto the watched bit's rising edge:
- The expiry is combinational in the cycle after E.
- The flags, the interrupt and the reset-request pulse all appear after edge E+1.
- The pulse is gone after edge E+2.

Timing for register accesses:
- Register writes take effect at the next edge.
- Reads are combinational.

How the checks keep to that timing:
- Every stimulus task starts and ends one time unit after a rising edge.
- Each check is queued with the current cycle number and compared by the monitor at the following falling edge.
- The bench therefore samples flags one step after each tick, and the reset request both in that cycle and in the cycle after it.

// File: rtl/stage_watchdog_pkg.sv
package stage_watchdog_pkg;
  localparam int TB_W        = 64;
  localparam int PER_W       = 6;
  localparam int REG_W       = 32;
  localparam int RC_W        = 2;
  // control layout
  localparam int CTL_PLO_MSB = 31;  // period[1:0]
  localparam int CTL_RC_LSB  = 28;  // reset-control field
  localparam int CTL_IE_BIT  = 26;  // interrupt enable
  localparam int CTL_PHI_LSB = 17;  // period[5:2]
  // status layout
  localparam int ST_A_BIT    = 31;
  localparam int ST_B_BIT    = 30;

  typedef struct packed {
    logic [PER_W-1:0] period;
    logic             irq_en;
    logic [RC_W-1:0]  rst_ctl;
  } wd_ctrl_t;
endpackage

// File: rtl/wd_timebase.sv
module wd_timebase #(
  parameter int TB_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en_i,
  output logic [TB_W-1:0] tb_o
);
  logic [TB_W-1:0] tb_q;
  logic [TB_W-1:0] tb_d;

  always_comb begin
    tb_d = tb_q + TB_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tb_q <= '0;
    else if (tick_en_i) tb_q <= tb_d;
  end

  assign tb_o = tb_q;

  // R1
  tb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en_i |=> (tb_o == $past(tb_o) + TB_W'(1)));

  // R1
  tb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en_i |=> $stable(tb_o));
endmodule

// File: rtl/wd_expiry_det.sv
module wd_expiry_det #(
  parameter int TB_W  = 64,
  parameter int PER_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TB_W-1:0]  tb_i,
  input  logic [PER_W-1:0] period_i,
  output logic             expiry_o
);
  // reversed view: index p addresses timebase bit TB_W-1-p
  logic [TB_W-1:0]  tb_rev;
  logic             sel_bit;
  logic             prev_bit_q;
  logic [PER_W-1:0] prev_per_q;

  for (genvar g = 0; g < TB_W; g++) begin : g_rev
    assign tb_rev[g] = tb_i[TB_W-1-g];
  end

  assign sel_bit  = tb_rev[period_i];
  assign expiry_o = sel_bit & ~prev_bit_q & (prev_per_q == period_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_bit_q <= 1'b0;
      prev_per_q <= '0;
    end else begin
      prev_bit_q <= sel_bit;
      prev_per_q <= period_i;
    end
  end

  // R9
  per_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expiry_o |-> $stable(period_i));

  // R2
  event_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expiry_o |=> !expiry_o);
endmodule

// File: rtl/wd_stage.sv
module wd_stage
  import stage_watchdog_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            expiry_i,
  input  logic            clr_a_i,
  input  logic            clr_b_i,
  input  logic [RC_W-1:0] rst_ctl_i,
  output logic            flag_a_o,
  output logic            flag_b_o,
  output logic            rst_req_o
);
  logic flag_a_q, flag_a_d;
  logic flag_b_q, flag_b_d;
  logic req_q, req_d;

  always_comb begin
    flag_a_d = flag_a_q & ~clr_a_i;
    flag_b_d = flag_b_q & ~clr_b_i;
    req_d    = 1'b0;
    if (expiry_i) begin
      if (!flag_a_q)      flag_a_d = 1'b1;
      else if (!flag_b_q) flag_b_d = 1'b1;
      else                req_d    = (rst_ctl_i != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a_q <= 1'b0;
      flag_b_q <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      flag_a_q <= flag_a_d;
      flag_b_q <= flag_b_d;
      req_q    <= req_d;
    end
  end

  assign flag_a_o  = flag_a_q;
  assign flag_b_o  = flag_b_q;
  assign rst_req_o = req_q;

  // R4
  arm_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a_q) |-> $past(expiry_i));

  // R5
  b_after_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_b_q) |-> $past(flag_a_q));

  // R6
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(flag_a_q && flag_b_q && (rst_ctl_i != '0)));

  // R6
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
endmodule

// File: rtl/wd_regs.sv
module wd_regs
  import stage_watchdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             flag_a_i,
  input  logic             flag_b_i,
  output wd_ctrl_t         ctrl_o,
  output logic             clr_a_o,
  output logic             clr_b_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam logic [REG_W-1:0] USED_MASK =
      (REG_W'(3) << (CTL_PLO_MSB - 1)) | (REG_W'(1) << CTL_IE_BIT)
    | (REG_W'(3) << CTL_RC_LSB) | (REG_W'((1 << (PER_W - 2)) - 1) << CTL_PHI_LSB)
    | (REG_W'(1) << ST_A_BIT) | (REG_W'(1) << ST_B_BIT);

  wd_ctrl_t ctrl_q, ctrl_d;
  logic     ctrl_we;
  logic     unused_wdata;

  assign ctrl_we      = wr_i & ~addr_i;
  assign clr_a_o      = wr_i & addr_i & wdata_i[ST_A_BIT];
  assign clr_b_o      = wr_i & addr_i & wdata_i[ST_B_BIT];
  assign unused_wdata = ^(wdata_i & ~USED_MASK);

  always_comb begin
    ctrl_d        = ctrl_q;
    ctrl_d.period = {wdata_i[CTL_PHI_LSB +: PER_W-2], wdata_i[CTL_PLO_MSB -: 2]};
    ctrl_d.irq_en = wdata_i[CTL_IE_BIT];
    if (ctrl_q.rst_ctl == '0) ctrl_d.rst_ctl = wdata_i[CTL_RC_LSB +: RC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_comb begin
    rdata_o = '0;
    if (!addr_i) begin
      rdata_o[CTL_PLO_MSB -: 2]          = ctrl_q.period[1:0];
      rdata_o[CTL_PHI_LSB +: PER_W-2]    = ctrl_q.period[PER_W-1:2];
      rdata_o[CTL_IE_BIT]                = ctrl_q.irq_en;
      rdata_o[CTL_RC_LSB +: RC_W]        = ctrl_q.rst_ctl;
    end else begin
      rdata_o[ST_A_BIT] = flag_a_i;
      rdata_o[ST_B_BIT] = flag_b_i;
    end
  end

  assign ctrl_o = ctrl_q;

  // R8
  rc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.rst_ctl != '0) |=> $stable(ctrl_q.rst_ctl));
endmodule

// File: rtl/stage_watchdog.sv
module stage_watchdog
  import stage_watchdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [TB_W-1:0]  tb_value,
  output logic             wd_irq,
  output logic             wd_rst_req
);
  wd_ctrl_t ctrl;
  logic     expiry;
  logic     clr_a, clr_b;
  logic     flag_a, flag_b;

  wd_timebase #(.TB_W(TB_W)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en_i (tick_en),
    .tb_o      (tb_value)
  );

  wd_expiry_det #(.TB_W(TB_W), .PER_W(PER_W)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .tb_i     (tb_value),
    .period_i (ctrl.period),
    .expiry_o (expiry)
  );

  wd_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (reg_wr),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .flag_a_i (flag_a),
    .flag_b_i (flag_b),
    .ctrl_o   (ctrl),
    .clr_a_o  (clr_a),
    .clr_b_o  (clr_b),
    .rdata_o  (reg_rdata)
  );

  wd_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .expiry_i  (expiry),
    .clr_a_i   (clr_a),
    .clr_b_i   (clr_b),
    .rst_ctl_i (ctrl.rst_ctl),
    .flag_a_o  (flag_a),
    .flag_b_o  (flag_b),
    .rst_req_o (wd_rst_req)
  );

  assign wd_irq = flag_b & ctrl.irq_en;
endmodule

// File: tb/stage_watchdog_test.sv
module stage_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_n, tick_en, reg_wr, reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [63:0] tb_value;
  logic        wd_irq, wd_rst_req;

  always #4 clk = ~clk;  // 125 MHz

  stage_watchdog uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tb_value(tb_value), .wd_irq(wd_irq), .wd_rst_req(wd_rst_req)
  );

  typedef struct {
    int          cyc;
    int          kind;   // 0 irq, 1 reset req, 2 read data, 3 timebase
    logic [63:0] exp;
    string       req;
  } item_t;

  item_t sb_q[$];
  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      item_t       it;
      logic [63:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = {63'b0, wd_irq};
        1:       act = {63'b0, wd_rst_req};
        2:       act = {32'b0, reg_rdata};
        default: act = tb_value;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  // driver side: push expected items for the current cycle
  function automatic void expect_now(int kind, logic [63:0] e, string req);
    item_t it;
    it.cyc = cyc; it.kind = kind; it.exp = e; it.req = req;
    sb_q.push_back(it);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tick();
    tick_en = 1'b1;
    @(posedge clk); #1;
    tick_en = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [31:0] e, input string req);
    reg_addr = a;
    expect_now(2, {32'b0, e}, req);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    // R10 reset state
    expect_now(0, 0, "R10"); expect_now(1, 0, "R10"); expect_now(3, 0, "R1");
    rd(1'b1, 32'h0, "R10");
    step();
    rd(1'b0, 32'h0, "R10");
    step();

    // R3 layout: period 63, irq enable, reset-control 1
    wr(1'b0, 32'hD41E_0000);
    rd(1'b0, 32'hD41E_0000, "R3");
    step();

    // R4 first expiry (count 0->1)
    tick(); step();
    rd(1'b1, 32'h8000_0000, "R4"); expect_now(0, 0, "R4"); expect_now(1, 0, "R4");
    step();
    // falling edge 1->2 has no effect (R2)
    tick(); step();
    rd(1'b1, 32'h8000_0000, "R2");
    // R5 second expiry (2->3)
    tick(); step();
    rd(1'b1, 32'hC000_0000, "R5"); expect_now(0, 1, "R5"); expect_now(1, 0, "R5");
    // R6 third expiry (4->5)
    tick(); tick(); step();
    expect_now(1, 1, "R6"); expect_now(3, 64'd5, "R1");
    step();
    expect_now(1, 0, "R6"); expect_now(0, 1, "R11");
    // R7 service
    wr(1'b1, 32'hC000_0000);
    rd(1'b1, 32'h0, "R7"); expect_now(0, 0, "R7");
    step();

    // R8 locked reset-control; R11 irq enable off
    wr(1'b0, 32'hE01E_0000);
    rd(1'b0, 32'hD01E_0000, "R8");
    step();
    tick(); tick(); step();   // count 7
    rd(1'b1, 32'h8000_0000, "R4");
    tick(); tick(); step();   // count 9
    rd(1'b1, 32'hC000_0000, "R11"); expect_now(0, 0, "R11");
    step();
    wr(1'b1, 32'hC000_0000);
    tick(); step();           // count 10: bit1=1, bit0=0
    rd(1'b1, 32'h0, "R7");
    step();

    // R9 switch to period 62 (bit 1, already 1)
    wr(1'b0, 32'h841E_0000);
    step(); step();
    rd(1'b1, 32'h0, "R9");
    step();
    rd(1'b0, 32'h941E_0000, "R3");
    step();
    // R2 bit 0 rising (11) must not count now
    tick(); step();
    rd(1'b1, 32'h0, "R2");
    tick(); tick(); step();   // count 13
    rd(1'b1, 32'h0, "R2");
    tick(); step();           // count 14: bit 1 rises
    rd(1'b1, 32'h8000_0000, "R2"); expect_now(3, 64'd14, "R1");
    step();

    // second reset
    rst_n = 1'b0;
    #1 expect_now(3, 0, "R10");
    step(); step();
    rst_n = 1'b1;
    rd(1'b1, 32'h0, "R10");
    step();

    // R6 with reset-control 0: no request
    wr(1'b0, 32'hC41E_0000);
    tick(); step();           // 1
    tick(); tick(); step();   // 3
    rd(1'b1, 32'hC000_0000, "R5");
    tick(); tick(); step();   // 5
    expect_now(1, 0, "R6");
    step();
    expect_now(1, 0, "R6");
    // R8 set then try to change
    wr(1'b0, 32'hF41E_0000);
    rd(1'b0, 32'hF41E_0000, "R8");
    step();
    wr(1'b0, 32'hD41E_0000);
    rd(1'b0, 32'hF41E_0000, "R8");
    step();
    tick(); tick(); step();   // 7
    expect_now(1, 1, "R6");
    step();
    expect_now(1, 0, "R6");
    step(); step();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule